// File: doc/BRIEF.md
# Register-Pair Stack Push Sequencer

This block runs the one-byte "push register pair" instruction of a small 8-bit processor core. The core presents an opcode byte with a one-clock start strobe. If the byte has the push shape, the block reads one of four 16-bit register pairs, chosen by a two-bit field of the opcode. It stores that pair as two bytes in memory just below the stack pointer, then lowers the stack pointer by two. An opcode without the push shape is rejected with a one-clock flag, and nothing else happens.

The stack pointer register lives inside the block. The core can load it through a load port while the block is idle, and always sees its value on an output. Execution takes a fixed twelve clock states: a six-state opcode fetch cycle, then two three-state memory write cycles. The high byte is written first and the low byte second. The register-pair inputs are only read, never written.

Top module: `stack_push_unit`

## Requirements
- R1: An opcode matching binary 11pp0101 (bits [7:6] = 11, bits [3:0] = 0101), presented with `start` while idle, begins a push. In hex these are C5, D5, E5 and F5.
- R2: The field pp is opcode bits [5:4]. 00 selects `pair_bc`, 01 selects `pair_de` and 10 selects `pair_hl`. 11 selects the word built from `acc` as the high byte and `flags` as the low byte, never the stack pointer.
- R3: The first write cycle drives address SP-1 with the high byte of the chosen pair. The second write cycle drives address SP-2 with the low byte.
- R4: Counting the state after the accepting edge as state 1: states 1-6 are the fetch cycle, 7-9 the high write and 10-12 the low write. `mem_we` is high only in states 8 and 11. `done` is high only in state 12. `busy` is high in states 1-12.
- R5: In the cycle after `done`, the stack pointer reads its old value minus 2, modulo 2^16. For example, 0x2000 gives 0x1FFE, and 0x0001 gives writes to 0x0000 and then 0xFFFF and leaves 0xFFFF.
- R6: A `start` with an opcode not matching 11xx0101 raises `illegal_op` for exactly the next cycle. It starts no push, produces no `mem_we`, and leaves the stack pointer unchanged.
- R7: The pair value is captured on the accepting edge. Changes on the pair inputs during the push do not alter the written bytes.
- R8: While `busy` is high, `start` and `sp_load` are ignored.
- R9: While idle, `sp_load` sets the stack pointer to `sp_load_val` on the next edge.
- R10: After synchronous reset (`rst_n` low at an edge), `busy`, `done`, `mem_we` and `illegal_op` are low and the stack pointer is 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Opcode valid strobe |
| opcode | input | 8 | Instruction byte |
| pair_bc | input | 16 | Register pair BC read port |
| pair_de | input | 16 | Register pair DE read port |
| pair_hl | input | 16 | Register pair HL read port |
| acc | input | 8 | Accumulator read port |
| flags | input | 8 | Condition flag byte read port |
| sp_load | input | 1 | Stack pointer load enable (idle only) |
| sp_load_val | input | 16 | Stack pointer load value |
| sp_value | output | 16 | Current stack pointer |
| mem_addr | output | 16 | Write address, valid in write cycles |
| mem_wdata | output | 8 | Write data byte, valid in write cycles |
| mem_we | output | 1 | One-clock write strobe |
| busy | output | 1 | Push in progress |
| done | output | 1 | Final state of the push |
| illegal_op | output | 1 | Rejected opcode, one clock |

## Verification
A state counter that is off by one moves the `mem_we` strobes and the `done` pulse away from states 8, 11 and 12. That shows up within the first push, since every state is sampled. A wrong pair-select mapping or wrong byte order shows up as a wrong `mem_wdata` in state 7 or 10. An opcode decode fault shows up at the first affected opcode, because all 256 opcodes are swept. A stack pointer update that is wrong, or that escapes the busy guard, is visible on `sp_value` one cycle after `done`. A wrap fault is caught by the sweeps at 0x0001 and 0x0000.

// File: rtl/pushseq_pkg.sv
// Package: shared constants and types for the register-pair push sequencer.
// Assumes an 8-bit data path with 16-bit addresses and register pairs.
package pushseq_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    // Opcode shape for push: top two bits and low nibble are fixed.
    localparam logic [1:0] PUSH_TOP_BITS = 2'b11;
    localparam logic [3:0] PUSH_LOW_BITS = 4'b0101;
    localparam int         SEL_LSB       = 4;

    typedef enum logic [1:0] {
        SEL_BC = 2'b00,
        SEL_DE = 2'b01,
        SEL_HL = 2'b10,
        SEL_AF = 2'b11
    } pair_sel_e;

endpackage

// File: rtl/push_decode.sv
// Module: push_decode
// Recognises the push opcode shape and extracts the two-bit pair field.
// Purely combinational; assumes the caller qualifies the result with its strobe.
module push_decode
    import pushseq_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output logic              is_push,
    output pair_sel_e         sel
);

    // Shape match on fixed bits and field extraction.
    always_comb begin
        is_push = (opcode[BYTE_W-1 -: 2] == PUSH_TOP_BITS) &&
                  (opcode[3:0] == PUSH_LOW_BITS);
        sel     = pair_sel_e'(opcode[SEL_LSB +: 2]);
    end

endmodule

// File: rtl/pair_select.sv
// Module: pair_select
// Four-way source multiplexer for the pushed word. Code 3 forms the word
// from accumulator (high byte) and flag byte (low byte); assumes stable inputs.
module pair_select
    import pushseq_pkg::*;
(
    input  pair_sel_e         sel,
    input  logic [WORD_W-1:0] pair_bc,
    input  logic [WORD_W-1:0] pair_de,
    input  logic [WORD_W-1:0] pair_hl,
    input  logic [BYTE_W-1:0] acc,
    input  logic [BYTE_W-1:0] flags,
    output logic [WORD_W-1:0] word
);

    // Select the source word for the current field code.
    always_comb begin
        unique case (sel)
            SEL_BC:  word = pair_bc;
            SEL_DE:  word = pair_de;
            SEL_HL:  word = pair_hl;
            default: word = {acc, flags};
        endcase
    end

endmodule

// File: rtl/push_timer.sv
// Module: push_timer
// Counts clock states of one push: a fetch machine cycle followed by two
// write machine cycles. State 0 is idle. Assumes go is only raised while idle.
module push_timer #(
    parameter int FETCH_ST = 6,
    parameter int WRITE_ST = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy,
    output logic wr_hi,
    output logic wr_lo,
    output logic wr_strobe,
    output logic last
);

    localparam int TOTAL_ST = FETCH_ST + 2 * WRITE_ST;
    localparam int TS_W     = $clog2(TOTAL_ST + 1);
    localparam logic [TS_W-1:0] HI_FIRST = TS_W'(FETCH_ST + 1);
    localparam logic [TS_W-1:0] HI_LAST  = TS_W'(FETCH_ST + WRITE_ST);
    localparam logic [TS_W-1:0] LO_FIRST = TS_W'(FETCH_ST + WRITE_ST + 1);
    localparam logic [TS_W-1:0] LO_LAST  = TS_W'(TOTAL_ST);
    localparam logic [TS_W-1:0] HI_STB   = TS_W'(FETCH_ST + 1 + WRITE_ST / 2);
    localparam logic [TS_W-1:0] LO_STB   = TS_W'(FETCH_ST + WRITE_ST + 1 + WRITE_ST / 2);

    logic [TS_W-1:0] tstate;

    // State counter: load 1 on go, advance while running, return to idle after the last state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tstate <= '0;
        else if (go)
            tstate <= TS_W'(1);
        else if (tstate == LO_LAST)
            tstate <= '0;
        else if (tstate != '0)
            tstate <= tstate + TS_W'(1);
    end

    // Machine-cycle phase decode from the state number.
    always_comb begin
        busy      = (tstate != '0);
        wr_hi     = (tstate >= HI_FIRST) && (tstate <= HI_LAST);
        wr_lo     = (tstate >= LO_FIRST) && (tstate <= LO_LAST);
        wr_strobe = (tstate == HI_STB) || (tstate == LO_STB);
        last      = (tstate == LO_LAST);
    end

    AST_GO_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !busy);                                           // R8
    AST_LAST_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !busy);                                         // R4
    AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> busy);                               // R4

endmodule

// File: rtl/stack_push_unit.sv
// Module: stack_push_unit (top)
// Executes the push-register-pair instruction. It holds the stack pointer,
// captures the chosen pair when a push is accepted, writes the high byte
// to SP-1 and then the low byte to SP-2, and drops SP by two after the last
// state. Assumes single-byte opcodes and a memory that takes one strobe per byte.
module stack_push_unit
    import pushseq_pkg::*;
#(
    parameter int                FETCH_ST = 6,
    parameter int                WRITE_ST = 3,
    parameter logic [WORD_W-1:0] SP_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BYTE_W-1:0] opcode,
    input  logic [WORD_W-1:0] pair_bc,
    input  logic [WORD_W-1:0] pair_de,
    input  logic [WORD_W-1:0] pair_hl,
    input  logic [BYTE_W-1:0] acc,
    input  logic [BYTE_W-1:0] flags,
    input  logic              sp_load,
    input  logic [WORD_W-1:0] sp_load_val,
    output logic [WORD_W-1:0] sp_value,
    output logic [WORD_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              busy,
    output logic              done,
    output logic              illegal_op
);

    logic              is_push;
    pair_sel_e         sel;
    logic [WORD_W-1:0] src_word;
    logic [WORD_W-1:0] held_word;
    logic [WORD_W-1:0] sp_q;
    logic              illegal_q;
    logic              go;
    logic              run;
    logic              wr_hi;
    logic              wr_lo;
    logic              wr_strobe;
    logic              last;

    push_decode u_decode (
        .opcode  (opcode),
        .is_push (is_push),
        .sel     (sel)
    );

    pair_select u_select (
        .sel     (sel),
        .pair_bc (pair_bc),
        .pair_de (pair_de),
        .pair_hl (pair_hl),
        .acc     (acc),
        .flags   (flags),
        .word    (src_word)
    );

    push_timer #(
        .FETCH_ST (FETCH_ST),
        .WRITE_ST (WRITE_ST)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .busy      (run),
        .wr_hi     (wr_hi),
        .wr_lo     (wr_lo),
        .wr_strobe (wr_strobe),
        .last      (last)
    );

    // Accept a push only when idle and the opcode has the push shape.
    always_comb go = start && !run && is_push;

    // Capture the source word on the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_word <= '0;
        else if (go)
            held_word <= src_word;
    end

    // Stack pointer: drop by two after the last state; load only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_q <= SP_RESET;
        else if (last)
            sp_q <= sp_q - WORD_W'(2);
        else if (sp_load && !run)
            sp_q <= sp_load_val;
    end

    // One-clock flag for a rejected opcode strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            illegal_q <= 1'b0;
        else
            illegal_q <= start && !run && !is_push;
    end

    // Memory bus: high byte to SP-1, then low byte to SP-2; zero outside writes.
    always_comb begin
        if (wr_lo) begin
            mem_addr  = sp_q - WORD_W'(2);
            mem_wdata = held_word[BYTE_W-1:0];
        end else if (wr_hi) begin
            mem_addr  = sp_q - WORD_W'(1);
            mem_wdata = held_word[WORD_W-1:BYTE_W];
        end else begin
            mem_addr  = '0;
            mem_wdata = '0;
        end
        mem_we     = wr_strobe;
        busy       = run;
        done       = last;
        sp_value   = sp_q;
        illegal_op = illegal_q;
    end

    AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (sp_value == $past(sp_value) - WORD_W'(2)));    // R5
    AST_SP_FROZEN_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(sp_value));                  // R8
    AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);                                        // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                         // R4
    AST_ILLEGAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> (!busy && !mem_we));                      // R6

endmodule

// File: tb/stack_push_unit_test.sv
`timescale 1ns/1ps
module stack_push_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [15:0] pair_bc = '0, pair_de = '0, pair_hl = '0;
    logic [7:0]  acc = '0, flags = '0;
    logic        sp_load = 1'b0;
    logic [15:0] sp_load_val = '0;
    logic [15:0] sp_value, mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we, busy, done, illegal_op;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    stack_push_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .pair_bc(pair_bc), .pair_de(pair_de), .pair_hl(pair_hl),
        .acc(acc), .flags(flags), .sp_load(sp_load), .sp_load_val(sp_load_val),
        .sp_value(sp_value), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .busy(busy), .done(done), .illegal_op(illegal_op)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one miscompare.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic run_case(input logic [7:0] op, input logic [15:0] sp0);
        logic [15:0] exp_word;
        logic [15:0] a1, a2;
        bit legal;
        // R9: load SP while idle
        sp_load = 1'b1; sp_load_val = sp0;
        @(negedge clk);
        sp_load = 1'b0;
        check(sp_value == sp0, "R9", "sp after load", 32'(sp_value), 32'(sp0));
        // Present distinct pair values derived from the case
        pair_bc = {op, sp0[7:0] ^ 8'h11};
        pair_de = {sp0[15:8] ^ 8'h22, op ^ 8'h5A};
        pair_hl = {op ^ 8'hA5, sp0[15:8]};
        acc     = sp0[7:0] ^ 8'h3C;
        flags   = op ^ 8'hC3;
        case (op[5:4])
            2'b00:   exp_word = pair_bc;
            2'b01:   exp_word = pair_de;
            2'b10:   exp_word = pair_hl;
            default: exp_word = {acc, flags};
        endcase
        legal = (op[7:6] == 2'b11) && (op[3:0] == 4'b0101);
        a1 = sp0 - 16'd1;
        a2 = sp0 - 16'd2;
        opcode = op; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R7: scramble the sources after the accepting edge
        pair_bc = ~pair_bc; pair_de = ~pair_de; pair_hl = ~pair_hl;
        acc = ~acc; flags = ~flags;
        if (!legal) begin
            check(illegal_op == 1'b1, "R6", "illegal flag", 32'(illegal_op), 1);
            check(busy == 1'b0, "R6", "busy after illegal", 32'(busy), 0);
            check(mem_we == 1'b0, "R6", "we after illegal", 32'(mem_we), 0);
            @(negedge clk);
            check(illegal_op == 1'b0, "R6", "illegal flag width", 32'(illegal_op), 0);
            check(sp_value == sp0, "R6", "sp after illegal", 32'(sp_value), 32'(sp0));
            check(busy == 1'b0, "R1", "no push for illegal", 32'(busy), 0);
        end else begin
            check(illegal_op == 1'b0, "R1", "no illegal flag", 32'(illegal_op), 0);
            for (int k = 1; k <= 12; k++) begin
                // R8: start and load in state 3 are ignored
                if (k == 3) begin
                    start = 1'b1; opcode = 8'hD5;
                    sp_load = 1'b1; sp_load_val = 16'h1234;
                end else begin
                    start = 1'b0; sp_load = 1'b0;
                end
                check(busy == 1'b1, "R4", "busy in run", 32'(busy), 1);
                check(mem_we == ((k == 8) || (k == 11)), "R4", "we timing",
                      32'(mem_we), 32'((k == 8) || (k == 11)));
                check(done == (k == 12), "R4", "done timing", 32'(done), 32'(k == 12));
                check(illegal_op == 1'b0, "R8", "no illegal in run", 32'(illegal_op), 0);
                if (k == 7 || k == 8 || k == 9) begin
                    check(mem_addr == a1, "R3", "high addr", 32'(mem_addr), 32'(a1));
                    check(mem_wdata == exp_word[15:8], "R2", "high byte (R7)",
                          32'(mem_wdata), 32'(exp_word[15:8]));
                end
                if (k >= 10) begin
                    check(mem_addr == a2, "R3", "low addr (R5 wrap)", 32'(mem_addr), 32'(a2));
                    check(mem_wdata == exp_word[7:0], "R2", "low byte (R7)",
                          32'(mem_wdata), 32'(exp_word[7:0]));
                end
                if (k < 4)
                    check(sp_value == sp0, "R8", "sp held in run", 32'(sp_value), 32'(sp0));
                if (k < 12) @(negedge clk);
            end
            @(negedge clk);
            check(busy == 1'b0, "R8", "idle after push", 32'(busy), 0);
            check(done == 1'b0, "R4", "done cleared", 32'(done), 0);
            check(sp_value == a2, "R5", "sp after push", 32'(sp_value), 32'(a2));
        end
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R10", "busy", 32'(busy), 0);
        check(done == 1'b0, "R10", "done", 32'(done), 0);
        check(mem_we == 1'b0, "R10", "we", 32'(mem_we), 0);
        check(illegal_op == 1'b0, "R10", "illegal", 32'(illegal_op), 0);
        check(sp_value == 16'h0000, "R10", "sp", 32'(sp_value), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // Exhaustive opcode sweep at several stack pointers, wrap included
        for (int s = 0; s < 4; s++) begin
            for (int op = 0; op < 256; op++) begin
                case (s)
                    0:       run_case(8'(op), 16'h2000);
                    1:       run_case(8'(op), 16'h0001);
                    2:       run_case(8'(op), 16'h0000);
                    default: run_case(8'(op), 16'h8001);
                endcase
            end
        end
        finish_run();
    end

endmodule